// File: doc/BRIEF.md
# Multiplier-free 8-point DCT engine

This block takes eight signed samples in parallel and returns the eight coefficients of their one-dimensional discrete cosine transform. No hardware multiplier is used. A butterfly stage first folds the samples into eight pre-sums: two even totals, four mirrored differences and two second-level even differences. Each output is then a weighted sum of at most four of these pre-sums with fixed cosine weights.

Each weighted sum is evaluated by a bit-serial distributed-arithmetic kernel. On every step, the kernel takes one bit from each of its pre-sums. That group of bits selects an entry in a small constant table holding every partial sum of the weights. The entry is added into an accumulator that shifts right by one place each step. The pre-sums are fed least significant bit first, and on the sign bit the table entry is subtracted instead of added. All eight kernels run in lockstep.

A start pulse captures a new vector. The eight coefficients then appear together with a one-cycle done pulse, and they stay on the outputs until the next result. A start pulse that arrives while a computation is running is ignored.

Top module: `dct8_da`

## Requirements
- R1: While reset is held and until the first computation completes, done is 0 and coef_out is all zeros.
- R2: Sample X(i) is x_in[i*DW +: DW], two's complement. Coefficient F(u) is coef_out[u*OW +: OW], two's complement, with OFRAC fraction bits. F(0) equals P·ΣX and F(4) equals P·(X0−X1−X2+X3+X4−X5−X6+X7), with P = cos(π/4)/2. Each result is within ±1 LSB of the value computed with weights rounded to 11 fraction bits and then rounded to nearest.
- R3: With A, B, C and D equal to cos(π/16)/2, cos(3π/16)/2, cos(5π/16)/2 and cos(7π/16)/2, and with d1..d4 = X0−X7, X1−X6, X2−X5, X3−X4, the odd outputs are F1 = Ad1+Bd2+Cd3+Dd4, F3 = Bd1−Dd2−Ad3−Cd4, F5 = Cd1−Ad2+Dd3+Bd4 and F7 = Dd1−Cd2+Bd3−Ad4. Each meets the same ±1 LSB bound.
- R4: With M = cos(π/8)/2, N = cos(3π/8)/2, e1 = X0−X3−X4+X7 and e2 = X1−X2−X5+X6, the outputs are F2 = Me1+Ne2 and F6 = Ne1−Me2, within ±1 LSB.
- R5: start is accepted at a rising edge while the block is idle. Counting that edge as the first, done is high for exactly one cycle after edge PW+1 (PW = DW+3). All eight coefficients change at that same edge.
- R6: A start pulse during a computation is ignored. It neither restarts the computation nor produces an extra done, and the result reflects the vector that was accepted.
- R7: coef_out holds its value in every cycle in which done is low.
- R8: Full-scale inputs, such as all samples at −2^(DW−1), all at 2^(DW−1)−1, or alternating extremes, give correct results without overflow. Every coefficient stays within ±363·2^OFRAC.
- R9: A start given in the cycle in which done is high is accepted, so computations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture x_in and begin a transform when idle |
| x_in | input | 8*DW | Eight samples, X(i) in bits [i*DW +: DW] |
| coef_out | output | 8*OW | Eight coefficients, F(u) in bits [u*OW +: OW] |
| done | output | 1 | One-cycle pulse when coef_out holds a new result |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 14-bit outputs and two output fraction bits. With these values the even total reaches the very edge of the 11-bit pre-sum range at −1024, and every kernel goes through a sign-bit subtraction on each vector. The scoreboard computes each coefficient from the cosine definition of the transform, with weights rounded independently, and checks the done timing against the cycle in which each start was accepted. Ignored starts and back-to-back starts are checked through the number and timing of done pulses.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  // Weight format: signed, 11 fraction bits
  localparam int CW    = 12;
  localparam int CFRAC = 11;

  localparam logic signed [CW-1:0] WA = 12'sd1004; // cos(pi/16)/2
  localparam logic signed [CW-1:0] WB = 12'sd851;  // cos(3pi/16)/2
  localparam logic signed [CW-1:0] WC = 12'sd569;  // cos(5pi/16)/2
  localparam logic signed [CW-1:0] WD = 12'sd200;  // cos(7pi/16)/2
  localparam logic signed [CW-1:0] WM = 12'sd946;  // cos(pi/8)/2
  localparam logic signed [CW-1:0] WN = 12'sd392;  // cos(3pi/8)/2
  localparam logic signed [CW-1:0] WP = 12'sd724;  // cos(pi/4)/2

  // Weights of odd row r, operand k at bits [k*CW +: CW]
  function automatic logic [4*CW-1:0] odd_row(int r);
    case (r)
      0:       return {WD, WC, WB, WA};
      1:       return {-WC, -WA, -WD, WB};
      2:       return {WB, WD, -WA, WC};
      default: return {-WA, WB, -WC, WD};
    endcase
  endfunction

  // Weights of the two-operand even rows (F2, F6)
  function automatic logic [4*CW-1:0] pair_row(int r);
    if (r == 0) return {{(2*CW){1'b0}}, WN, WM};
    return {{(2*CW){1'b0}}, -WM, WN};
  endfunction

  function automatic logic [4*CW-1:0] dc_row();
    return {{(3*CW){1'b0}}, WP};
  endfunction
endpackage

// File: rtl/dct8_presum.sv
module dct8_presum #(
  parameter int DW = 8,
  parameter int PW = DW + 3
) (
  input  logic [8*DW-1:0] x,
  output logic [8*PW-1:0] ps
);
  function automatic logic signed [PW-1:0] sx(logic [DW-1:0] v);
    return {{(PW-DW){v[DW-1]}}, v};
  endfunction

  logic signed [PW-1:0] s [8];

  always_comb begin
    for (int i = 0; i < 8; i++) s[i] = sx(x[i*DW +: DW]);
    // order: even total, even alternating, four mirrored diffs, two second-level diffs
    ps[0*PW +: PW] = s[0] + s[1] + s[2] + s[3] + s[4] + s[5] + s[6] + s[7];
    ps[1*PW +: PW] = s[0] - s[1] - s[2] + s[3] + s[4] - s[5] - s[6] + s[7];
    ps[2*PW +: PW] = s[0] - s[7];
    ps[3*PW +: PW] = s[1] - s[6];
    ps[4*PW +: PW] = s[2] - s[5];
    ps[5*PW +: PW] = s[3] - s[4];
    ps[6*PW +: PW] = s[0] - s[3] - s[4] + s[7];
    ps[7*PW +: PW] = s[1] - s[2] - s[5] + s[6];
  end
endmodule

// File: rtl/dct8_ctrl.sv
module dct8_ctrl #(
  parameter int PW = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);
  localparam int CNTW = $clog2(PW);

  logic            busy_q;
  logic [CNTW-1:0] cnt_q;

  assign load = start && !busy_q;
  assign step = busy_q;
  assign last = busy_q && (cnt_q == CNTW'(PW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + CNTW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dct8_da_kernel.sv
module dct8_da_kernel #(
  parameter int K     = 4,
  parameter int PW    = 11,
  parameter int LW    = 15,
  parameter int AW    = 26,
  parameter int SHIFT = 9,
  parameter int OW    = 14,
  parameter logic [4*dct8_pkg::CW-1:0] COEF = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          last,
  input  logic [K-1:0]  bits,
  output logic [OW-1:0] y
);
  import dct8_pkg::*;

  localparam logic signed [AW-1:0] HALF = AW'(1) << (SHIFT - 1);

  // Constant table entry: sum of the weights whose select bit is set
  function automatic logic signed [LW-1:0] entry(int e);
    logic signed [LW-1:0] acc;
    logic signed [CW-1:0] c;
    acc = '0;
    for (int k = 0; k < K; k++) begin
      c = COEF[k*CW +: CW];
      if (e[k]) acc = acc + {{(LW-CW){c[CW-1]}}, c};
    end
    return acc;
  endfunction

  logic signed [LW-1:0] lut [2**K];
  for (genvar e = 0; e < 2**K; e++) begin : g_lut
    assign lut[e] = entry(e);
  end

  logic signed [LW-1:0] lut_out, term;
  logic signed [AW-1:0] ext, acc_q, acc_nxt, rsum;

  always_comb begin
    lut_out = lut[bits];
    term    = last ? -lut_out : lut_out;   // sign bit carries negative weight
    ext     = {{(AW-LW){term[LW-1]}}, term};
    acc_nxt = (acc_q >>> 1) + (ext <<< (PW - 1));
    rsum    = acc_nxt + HALF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      y     <= '0;
    end else begin
      if (clr) acc_q <= '0;
      else if (step) acc_q <= acc_nxt;
      if (step && last) y <= OW'(rsum >>> SHIFT);
    end
  end
endmodule

// File: rtl/dct8_da.sv
module dct8_da #(
  parameter int DW    = 8,
  parameter int OW    = 14,
  parameter int OFRAC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [8*DW-1:0] x_in,
  output logic [8*OW-1:0] coef_out,
  output logic          done
);
  import dct8_pkg::*;

  localparam int PW    = DW + 3;
  localparam int LW    = CW + 3;
  localparam int AW    = LW + PW;
  localparam int SHIFT = CFRAC - OFRAC;

  logic load_w, step_w, last_w;
  logic [8*PW-1:0] ps;
  logic signed [PW-1:0] ps_q [8];
  logic [OW-1:0] fy [8];

  dct8_presum #(.DW(DW), .PW(PW)) u_presum (.x(x_in), .ps(ps));

  dct8_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load_w), .step(step_w), .last(last_w), .done(done)
  );

  // Pre-sum registers shift right so bit 0 is the current serial bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) ps_q[i] <= '0;
    end else if (load_w) begin
      for (int i = 0; i < 8; i++) ps_q[i] <= ps[i*PW +: PW];
    end else if (step_w) begin
      for (int i = 0; i < 8; i++) ps_q[i] <= ps_q[i] >>> 1;
    end
  end

  // F0, F4: single operand
  for (genvar g = 0; g < 2; g++) begin : g_dc
    dct8_da_kernel #(.K(1), .PW(PW), .LW(LW), .AW(AW), .SHIFT(SHIFT), .OW(OW),
                     .COEF(dc_row())) u_k (
      .clk(clk), .rst_n(rst_n), .clr(load_w), .step(step_w), .last(last_w),
      .bits(ps_q[g][0]), .y(fy[4*g])
    );
  end

  // F1, F3, F5, F7: four mirrored differences
  for (genvar r = 0; r < 4; r++) begin : g_odd
    dct8_da_kernel #(.K(4), .PW(PW), .LW(LW), .AW(AW), .SHIFT(SHIFT), .OW(OW),
                     .COEF(odd_row(r))) u_k (
      .clk(clk), .rst_n(rst_n), .clr(load_w), .step(step_w), .last(last_w),
      .bits({ps_q[5][0], ps_q[4][0], ps_q[3][0], ps_q[2][0]}), .y(fy[2*r+1])
    );
  end

  // F2, F6: two second-level differences
  for (genvar e = 0; e < 2; e++) begin : g_even
    dct8_da_kernel #(.K(2), .PW(PW), .LW(LW), .AW(AW), .SHIFT(SHIFT), .OW(OW),
                     .COEF(pair_row(e))) u_k (
      .clk(clk), .rst_n(rst_n), .clr(load_w), .step(step_w), .last(last_w),
      .bits({ps_q[7][0], ps_q[6][0]}), .y(fy[2+4*e])
    );
  end

  for (genvar u = 0; u < 8; u++) begin : g_out
    assign coef_out[u*OW +: OW] = fy[u];
  end
endmodule

// File: rtl/dct8_da_chk.sv
module dct8_da_chk #(
  parameter int OW    = 14,
  parameter int PW    = 11,
  parameter int OFRAC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [8*OW-1:0] coef_out,
  input logic          load
);
  localparam int LIM = 363 * (2 ** OFRAC);

  int   since_load;
  logic pending, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_load <= 0;
      pending    <= 1'b0;
      armed      <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (load) begin
        since_load <= 1;
        pending    <= 1'b1;
      end else if (done) begin
        since_load <= 0;
        pending    <= 1'b0;
      end else if (since_load != 0) begin
        since_load <= since_load + 1;
      end
    end
  end

  function automatic logic in_range(logic [8*OW-1:0] v);
    logic signed [OW-1:0] s;
    in_range = 1'b1;
    for (int u = 0; u < 8; u++) begin
      s = v[u*OW +: OW];
      if (s > LIM || s < -LIM) in_range = 1'b0;
    end
  endfunction

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n) done |-> (since_load == PW + 1));
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> pending);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) (armed && !done) |-> $stable(coef_out));
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n) in_range(coef_out));
endmodule

bind dct8_da dct8_da_chk #(.OW(OW), .PW(PW), .OFRAC(OFRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .coef_out(coef_out), .load(load_w)
);

// File: tb/dct8_da_bench.sv
module dct8_da_bench;
  localparam int DW = 8, OW = 14, OFRAC = 2;
  localparam int SH = 11 - OFRAC;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [8*DW-1:0] x_in = '0;
  wire  [8*OW-1:0] coef_out;
  wire  done;

  dct8_da #(.DW(DW), .OW(OW), .OFRAC(OFRAC)) u_dct8_da (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .coef_out(coef_out), .done(done)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int errors = 0, checks = 0;
  int wq [8][8];
  int expq[$];
  int cycq[$];
  string tagq[$];
  logic [8*OW-1:0] last_out = '0;
  bit finished = 0;

  function automatic int qc(real r);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: present a vector in the current negedge slot, push its expectation if it should be taken
  task automatic send_now(input int xs [8], input string tag, input bit accept);
    longint sum;
    for (int i = 0; i < 8; i++) x_in[i*DW +: DW] = xs[i][DW-1:0];
    start = 1'b1;
    if (accept) begin
      for (int u = 0; u < 8; u++) begin
        sum = 0;
        for (int i = 0; i < 8; i++) sum += longint'(xs[i]) * wq[u][i];
        expq.push_back(int'((sum + (64'sd1 <<< (SH - 1))) >>> SH));
      end
      cycq.push_back(cyc + 1);
      tagq.push_back(tag);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input int xs [8], input string tag);
    @(negedge clk);
    send_now(xs, tag, 1'b1);
  endtask

  task automatic wait_idle();
    while (cycq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare each result and the hold behaviour between results
  initial begin
    int c0, e, a;
    string t, rq;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (done) begin
        if (cycq.size() == 0) begin
          check(1'b0, "R6 spurious done", 1, 0);
        end else begin
          c0 = cycq.pop_front();
          t  = tagq.pop_front();
          check(cyc == c0 + 11, {"R5 latency ", t}, cyc - c0, 11);
          for (int u = 0; u < 8; u++) begin
            e = expq.pop_front();
            a = int'($signed(coef_out[u*OW +: OW]));
            rq = (u == 0 || u == 4) ? "R2" : ((u % 2 == 1) ? "R3" : "R4");
            check((a - e) <= 1 && (e - a) <= 1, $sformatf("%s %s F%0d", rq, t, u), a, e);
          end
        end
        last_out = coef_out;
      end else begin
        check(coef_out == last_out, "R7 hold", int'(coef_out[OW-1:0]), int'(last_out[OW-1:0]));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int v [8];
    real cu;
    for (int u = 0; u < 8; u++) begin
      cu = (u == 0) ? 0.70710678118655 : 1.0;
      for (int i = 0; i < 8; i++)
        wq[u][i] = qc(2048.0 * 0.5 * cu * $cos(real'((2 * i + 1) * u) * PI / 16.0));
    end

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(coef_out == '0, "R1 coef_out in reset", int'(coef_out[OW-1:0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(coef_out == '0, "R1 coef_out after reset", int'(coef_out[OW-1:0]), 0);

    v = '{0, 0, 0, 0, 0, 0, 0, 0};          send(v, "R2 zero");       wait_idle();
    v = '{10, 10, 10, 10, 10, 10, 10, 10};  send(v, "R2 flat");       wait_idle();
    v = '{-7, 3, 12, -40, 25, 60, -90, 5};  send(v, "R3 mixed");      wait_idle();
    v = '{0, 16, 32, 48, 64, 80, 96, 112};  send(v, "R4 ramp");       wait_idle();
    for (int k = 0; k < 8; k++) begin
      v = '{0, 0, 0, 0, 0, 0, 0, 0};
      v[k] = 100;
      send(v, $sformatf("R3 impulse%0d", k));
      wait_idle();
    end

    v = '{-128, -128, -128, -128, -128, -128, -128, -128}; send(v, "R8 allneg");  wait_idle();
    v = '{127, 127, 127, 127, 127, 127, 127, 127};         send(v, "R8 allpos");  wait_idle();
    v = '{127, -128, 127, -128, 127, -128, 127, -128};     send(v, "R8 alt1");    wait_idle();
    v = '{-128, 127, -128, 127, -128, 127, -128, 127};     send(v, "R8 alt2");    wait_idle();
    v = '{127, -128, -128, 127, 127, -128, -128, 127};     send(v, "R8 evenalt"); wait_idle();
    v = '{127, 127, 127, 127, -128, -128, -128, -128};     send(v, "R8 step");    wait_idle();
    v = '{-128, 127, 127, -128, -128, 127, 127, -128};     send(v, "R8 evenalt2"); wait_idle();

    // R6: a second start mid-computation must be ignored
    v = '{50, -20, 33, 7, -99, 64, 1, -5}; send(v, "R6 first");
    repeat (4) @(negedge clk);
    v = '{-1, -2, -3, -4, -5, -6, -7, -8}; send_now(v, "R6 ignored", 1'b0);
    wait_idle();
    repeat (20) @(negedge clk);

    // R9: restart in the done cycle
    v = '{3, 1, 4, 1, 5, 9, 2, 6}; send(v, "R9 a");
    for (int n = 0; n < 3; n++) begin
      do @(negedge clk); while (!done);
      v = '{-90 + n, 77, -13, 100 - n, -128, 127, 8 * n, -64};
      send_now(v, $sformatf("R9 b%0d", n), 1'b1);
    end
    wait_idle();

    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < 8; i++) v[i] = int'($urandom_range(0, 255)) - 128;
      send(v, $sformatf("R3 rand%0d", n));
      wait_idle();
    end

    repeat (10) @(negedge clk);
    check(cycq.size() == 0, "R6 pending results", cycq.size(), 0);
    finish_run();
  end
endmodule